// File: doc/BRIEF.md
# AUX Reply Timeout Encoder and Timer

This block turns a reply timeout requested in microseconds into a two-field hardware setting: a 2-bit scale code and a 7-bit length. Each scale code stands for a tick unit of 8, 16, 32 or 64 microseconds. The stored setting then drives a reply-wait timer. The timer is armed when a request has finished transmitting. It is disarmed when a reply begins. If the programmed number of microseconds passes first, it raises a timeout flag.

A load strobe captures the new timeout. In the same edge the block reports the setting it is replacing, converted back to microseconds. This lets the caller restore the setting later. The microsecond time base comes from a one-cycle tick input, so the timer works independently of the clock frequency. Reply reception itself is handled elsewhere.

Top module: `aux_reply_timer`

## Requirements
- R1: After reset, the scale code is 0, the length is 69, the previous-setting output is 0 and the timeout flag is low.
- R2: A load with a requested value of 0 stores scale code 0 and length 69.
- R3: A load with a value from 1 to 1016 stores scale code 0 and a length equal to the value divided by 8, rounded up.
- R4: A load with a value from 1017 to 2032 stores scale code 1 and a length equal to the value divided by 16, rounded up.
- R5: A load with a value from 2033 to 4064 stores scale code 2 and a length equal to the value divided by 32, rounded up.
- R6: A load with a value above 4064 stores scale code 3 and a length equal to the value divided by 64, rounded up.
- R7: A computed length above 127 is stored as 127.
- R8: Each load sets the previous-setting output to the replaced length times 8, 16, 32 or 64 for scale codes 0, 1, 2 or 3. Without a load, the output holds its value.
- R9: After a start, the timeout flag rises at the clock edge that samples the Nth tick, where N is the length times the tick unit. It does not rise before that edge.
- R10: A stop sampled before the Nth tick, including in the same cycle as that tick, disarms the timer, and the flag stays low.
- R11: A start clears the flag and restarts the count. A start takes priority over a stop sampled in the same cycle.
- R12: The stored setting changes only on a load. A running wait uses the setting captured at its start, so a load during the wait has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_us | input | 16 | Requested reply timeout in microseconds |
| cfg_load | input | 1 | Strobe that stores the encoding of cfg_us |
| wait_start | input | 1 | Request sent; arm the timer |
| wait_stop | input | 1 | Reply began; disarm the timer |
| tick_us | input | 1 | One-cycle pulse each microsecond |
| mul_code | output | 2 | Stored scale code |
| len_code | output | 7 | Stored length |
| prev_us | output | 13 | Replaced setting in microseconds, updated on load |
| timed_out | output | 1 | Reply wait expired |

## Verification
The hardest cases to reach are those where the timer's final tick lands in the same cycle as a stop, or where the setting is reloaded in the middle of a wait. The stimulus first loads a short setting of 8 ticks. It then counts ticks one at a time up to the limit and places the stop or the reload exactly on the chosen tick. The encoding boundaries come from a vector table that walks each range edge on both sides, as well as the saturation points. In that table, each load also checks the value reported for the setting it replaces.

// File: rtl/aux_to_pkg.sv
package aux_to_pkg;
  localparam int TO_LEN_W   = 7;
  localparam int TO_MUL_W   = 2;
  localparam int BASE_SHIFT = 3;
  localparam int TO_MAX_LEN = (1 << TO_LEN_W) - 1;
  localparam int TICK_W     = TO_LEN_W + BASE_SHIFT + (1 << TO_MUL_W) - 1;

  typedef struct packed {
    logic [TO_MUL_W-1:0] mul;
    logic [TO_LEN_W-1:0] len;
  } to_setting_t;

  // Piecewise scale choice followed by ceiling division and saturation.
  function automatic to_setting_t to_encode(input int unsigned us,
                                            input int unsigned step,
                                            input int unsigned def_len);
    to_setting_t s;
    int unsigned m, sh, l;
    if (us == 0) begin
      s.mul = '0;
      s.len = TO_LEN_W'(def_len);
    end else begin
      m = 0;
      if (us > step)     m = 1;
      if (us > 2 * step) m = 2;
      if (us > 4 * step) m = 3;
      sh = BASE_SHIFT + m;
      l  = (us + (32'd1 << sh) - 1) >> sh;
      if (l > TO_MAX_LEN) l = TO_MAX_LEN;
      s.mul = TO_MUL_W'(m);
      s.len = TO_LEN_W'(l);
    end
    return s;
  endfunction

  // Setting expressed back in microsecond ticks.
  function automatic logic [TICK_W-1:0] to_decode(input to_setting_t s);
    return TICK_W'(s.len) << (BASE_SHIFT + int'(s.mul));
  endfunction
endpackage

// File: rtl/aux_to_encoder.sv
module aux_to_encoder
  import aux_to_pkg::*;
#(
  parameter int US_W    = 16,
  parameter int STEP_US = 1016,
  parameter int DEF_LEN = 69
) (
  input  logic [US_W-1:0] req_us,
  output to_setting_t     enc
);
  always_comb enc = to_encode(int'(req_us), STEP_US, DEF_LEN);
endmodule

// File: rtl/aux_to_timer.sv
module aux_to_timer
  import aux_to_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  to_setting_t cur,
  input  logic        wait_start,
  input  logic        wait_stop,
  input  logic        tick_us,
  output logic        armed,
  output logic        expire_evt,
  output logic        timed_out
);
  logic [TICK_W-1:0] limit_q;
  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W-1:0] cnt_nx;

  assign cnt_nx     = cnt_q + 1'b1;
  assign expire_evt = armed && !wait_start && !wait_stop && tick_us && (cnt_nx == limit_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      cnt_q     <= '0;
      limit_q   <= '0;
      timed_out <= 1'b0;
    end else if (wait_start) begin
      armed     <= 1'b1;
      cnt_q     <= '0;
      limit_q   <= to_decode(cur);
      timed_out <= 1'b0;
    end else if (armed) begin
      if (wait_stop) begin
        armed <= 1'b0;
      end else if (tick_us) begin
        cnt_q <= cnt_nx;
        if (expire_evt) begin
          armed     <= 1'b0;
          timed_out <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aux_reply_timer.sv
module aux_reply_timer
  import aux_to_pkg::*;
#(
  parameter int US_W    = 16,
  parameter int STEP_US = 1016,
  parameter int DEF_LEN = 69
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [US_W-1:0]     cfg_us,
  input  logic                cfg_load,
  input  logic                wait_start,
  input  logic                wait_stop,
  input  logic                tick_us,
  output logic [TO_MUL_W-1:0] mul_code,
  output logic [TO_LEN_W-1:0] len_code,
  output logic [TICK_W-1:0]   prev_us,
  output logic                timed_out
);
  to_setting_t enc;
  to_setting_t cur_q;
  logic        armed;
  logic        expire_evt;

  aux_to_encoder #(.US_W(US_W), .STEP_US(STEP_US), .DEF_LEN(DEF_LEN)) u_enc (
    .req_us (cfg_us),
    .enc    (enc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q.mul <= '0;
      cur_q.len <= TO_LEN_W'(DEF_LEN);
      prev_us   <= '0;
    end else if (cfg_load) begin
      cur_q   <= enc;
      prev_us <= to_decode(cur_q);
    end
  end

  assign mul_code = cur_q.mul;
  assign len_code = cur_q.len;

  aux_to_timer u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur        (cur_q),
    .wait_start (wait_start),
    .wait_stop  (wait_stop),
    .tick_us    (tick_us),
    .armed      (armed),
    .expire_evt (expire_evt),
    .timed_out  (timed_out)
  );
endmodule

// File: rtl/aux_reply_timer_chk.sv
module aux_reply_timer_chk
  import aux_to_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_load,
  input logic                wait_start,
  input logic                wait_stop,
  input logic                tick_us,
  input logic [TO_MUL_W-1:0] mul_code,
  input logic [TO_LEN_W-1:0] len_code,
  input logic [TICK_W-1:0]   prev_us,
  input logic                timed_out,
  input logic                armed,
  input logic                expire_evt
);
  assert_len_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    len_code != '0);

  assert_prev_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> prev_us == (TICK_W'($past(len_code)) << (BASE_SHIFT + int'($past(mul_code)))));

  assert_prev_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(prev_us));

  assert_setting_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(len_code) && $stable(mul_code)));

  assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> ($past(expire_evt) && $past(tick_us) && $past(armed)));

  assert_stop_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_stop && !wait_start && !timed_out) |=> (!timed_out && !armed));

  assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wait_start |=> (!timed_out && armed));
endmodule

bind aux_reply_timer aux_reply_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .wait_start (wait_start),
  .wait_stop  (wait_stop),
  .tick_us    (tick_us),
  .mul_code   (mul_code),
  .len_code   (len_code),
  .prev_us    (prev_us),
  .timed_out  (timed_out),
  .armed      (armed),
  .expire_evt (expire_evt)
);

// File: tb/aux_reply_timer_tb.sv
module aux_reply_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_us = '0;
  logic        cfg_load = 1'b0, wait_start = 1'b0, wait_stop = 1'b0, tick_us = 1'b0;
  logic [1:0]  mul_code;
  logic [6:0]  len_code;
  logic [12:0] prev_us;
  logic        timed_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aux_reply_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_us(cfg_us), .cfg_load(cfg_load),
    .wait_start(wait_start), .wait_stop(wait_stop), .tick_us(tick_us),
    .mul_code(mul_code), .len_code(len_code), .prev_us(prev_us), .timed_out(timed_out)
  );

  // {request us, expected code, expected length}
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {16'd0,     2'd0, 7'd69},  {16'd1,    2'd0, 7'd1},
    {16'd8,     2'd0, 7'd1},   {16'd9,    2'd0, 7'd2},
    {16'd1016,  2'd0, 7'd127}, {16'd1017, 2'd1, 7'd64},
    {16'd2032,  2'd1, 7'd127}, {16'd2033, 2'd2, 7'd64},
    {16'd4064,  2'd2, 7'd127}, {16'd4065, 2'd3, 7'd64},
    {16'd8128,  2'd3, 7'd127}, {16'd8129, 2'd3, 7'd127},
    {16'd65535, 2'd3, 7'd127}, {16'd100,  2'd0, 7'd13}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int us);
    @(negedge clk); cfg_us = 16'(us); cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic start_wait();
    @(negedge clk); wait_start = 1'b1;
    @(negedge clk); wait_start = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_us = 1'b1;
      @(negedge clk); tick_us = 1'b0;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int exp_prev;
    string rq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mul", mul_code, 0);
    chk("R1 len", len_code, 69);
    chk("R1 prev", prev_us, 0);
    chk("R1 flag", timed_out, 0);

    // R9 default setting: 69*8 = 552 ticks
    start_wait();
    ticks(551);
    chk("R9 early", timed_out, 0);
    ticks(1);
    chk("R9 expire", timed_out, 1);

    // Encoding table, R2..R8
    exp_prev = 69 * 8;
    for (int i = 0; i < NV; i++) begin
      int us, em, el;
      us = int'(VEC[i][24:9]); em = int'(VEC[i][8:7]); el = int'(VEC[i][6:0]);
      load(us);
      if (us == 0) rq = "R2";
      else if (us <= 1016) rq = (el == 127) ? "R7/R3" : "R3";
      else if (us <= 2032) rq = (el == 127) ? "R7/R4" : "R4";
      else if (us <= 4064) rq = (el == 127) ? "R7/R5" : "R5";
      else rq = (el == 127) ? "R7/R6" : "R6";
      chk({rq, " mul"}, mul_code, em);
      chk({rq, " len"}, len_code, el);
      chk("R8 prev", prev_us, exp_prev);
      exp_prev = el * (8 << em);
    end

    // R12 and R8 hold without load
    ticks(3);
    chk("R12 len hold", len_code, 13);
    chk("R8 prev hold", prev_us, 127 * 64);

    // R10 stop before limit; setting 5 us -> 8 ticks
    load(5);
    start_wait();
    ticks(5);
    @(negedge clk); wait_stop = 1'b1;
    @(negedge clk); wait_stop = 1'b0;
    ticks(10);
    chk("R10 early stop", timed_out, 0);
    // R10 stop in same cycle as final tick
    start_wait();
    ticks(7);
    @(negedge clk); tick_us = 1'b1; wait_stop = 1'b1;
    @(negedge clk); tick_us = 1'b0; wait_stop = 1'b0;
    ticks(4);
    chk("R10 stop on last tick", timed_out, 0);

    // R11 restart clears flag; start beats stop
    start_wait();
    ticks(8);
    chk("R11 expire", timed_out, 1);
    start_wait();
    chk("R11 cleared", timed_out, 0);
    @(negedge clk); wait_start = 1'b1; wait_stop = 1'b1;
    @(negedge clk); wait_start = 1'b0; wait_stop = 1'b0;
    ticks(7);
    chk("R11 still counting", timed_out, 0);
    ticks(1);
    chk("R11 start wins", timed_out, 1);

    // R12 load mid-wait does not alter running limit
    start_wait();
    ticks(3);
    load(1016);
    chk("R12 new len", len_code, 127);
    ticks(4);
    chk("R12 not early", timed_out, 0);
    ticks(1);
    chk("R12 old limit", timed_out, 1);

    done = 1'b1;
    summary();
  end
endmodule